// File: doc/BRIEF.md
# Fourth-Order CIC Interpolator, Factor Two

This block raises the sample rate of a signed stream by two with a cascaded integrator-comb structure. Each sample taken in at the low rate is first attenuated by an arithmetic right shift of three bits. It then runs through four first-difference comb stages. The comb result goes into four accumulating stages as one high-rate slot, followed by a slot carrying zero. Every slot produces one output word.

The caller presents a sample with a valid strobe and holds it until the block signals readiness. Readiness is withdrawn while the zero slot is still owed, so the block takes at most one sample every two cycles. Output words leave with their own valid strobe, one per slot. Each word is the raw value of the last accumulator, with no gain correction applied. All arithmetic wraps modulo 2^32, so accumulator overflow cancels through the comb differences.

Top module: `cic_interp`

## Requirements
- R1: `in_ready` is high exactly when no zero slot is owed; a sample is taken only on a rising clock edge with `in_valid` and `in_ready` both high, and `in_ready` is low in the cycle after a sample is taken.
- R2: Each sample is scaled by an arithmetic (sign-preserving) right shift of 3 bits before the first comb, so -1 stays -1 and -9 becomes -2.
- R3: Each of the four comb stages outputs its input minus the input it received with the previous taken sample, and then stores the current input; stage k feeds stage k+1 within the same sample.
- R4: Every taken sample yields exactly two consecutive output slots, with `out_valid` high in the two cycles after the taking edge: first the comb result is fed to the accumulators, then zero.
- R5: Within one slot, accumulator 1 adds the slot value, and each later accumulator adds the freshly updated value of the one before it.
- R6: `out_data` is the value of accumulator 4 with no normalisation, so a held input of v gives a settled output of 8*(v>>>3).
- R7: All sums and differences wrap modulo 2^32 without saturation.
- R8: Synchronous active-high reset clears every comb store, every accumulator and the slot counter; after reset `out_valid` is 0, `out_data` is 0 and `in_ready` is 1.
- R9: A sample presented while `in_ready` is low is ignored and has no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both rates; one cycle is one high-rate slot |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Low-rate sample present |
| in_data | input | 32 | Signed low-rate sample |
| in_ready | output | 1 | Block can take a sample this cycle |
| out_valid | output | 1 | High-rate word present |
| out_data | output | 32 | Signed high-rate word (last accumulator) |

## Verification
The embedded properties assume that reset is held for at least one clock edge at start-up, so every `$past` they use has a defined history, and that `in_valid` and `in_data` change only away from the rising edge. They make no assumption about how often samples arrive or whether the caller keeps `in_valid` high while the block is busy. The stimulus covers both cases: it drives samples back to back, separated by idle gaps, and with `in_valid` held high on junk data during the owed zero slot. All inputs change on the falling edge.

// File: rtl/cic_pkg.sv
package cic_pkg;

   localparam int unsigned CIC_DATA_W = 32;
   localparam int unsigned CIC_ORDER  = 4;
   localparam int unsigned CIC_RATE   = 2;
   localparam int unsigned CIC_SHIFT  = 3;

   // kind of work done in the current high-rate cycle
   typedef enum logic [1:0] {
      SLOT_IDLE   = 2'd0,
      SLOT_SAMPLE = 2'd1,
      SLOT_ZERO   = 2'd2
   } slot_e;

endpackage

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl
   import cic_pkg::*;
#(
   parameter int unsigned RATE = CIC_RATE
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  in_valid,
   output logic  in_ready,
   output slot_e slot
);

   localparam int unsigned PH_W = (RATE > 2) ? $clog2(RATE) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATE - 1);

   generate
      if (RATE < 2) begin : g_bad_rate
         $error("cic_rate_ctrl: RATE must be at least 2");
      end
   endgenerate

   logic [PH_W-1:0] phase_q;
   logic            take;

   assign in_ready = (phase_q == '0);
   assign take     = in_valid && in_ready;

   always_comb begin
      if (take)                slot = SLOT_SAMPLE;
      else if (phase_q != '0)  slot = SLOT_ZERO;
      else                     slot = SLOT_IDLE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
      end else if (take) begin
         phase_q <= PH_W'(1);
      end else if (phase_q != '0) begin
         phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
      end
   end

   // R4: a taken sample is always followed by a zero slot
   a_r4_zero_follows: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> (slot == SLOT_ZERO));

   // R1: no sample is taken while a zero slot is owed
   a_r1_busy_blocks: assert property (@(posedge clk) disable iff (rst)
      (!in_ready) |-> (slot != SLOT_SAMPLE));

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain
   import cic_pkg::*;
#(
   parameter int unsigned DATA_W = CIC_DATA_W,
   parameter int unsigned ORDER  = CIC_ORDER,
   parameter int unsigned SHIFT  = CIC_SHIFT
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] din,
   output logic signed [DATA_W-1:0] dout
);

   generate
      if (ORDER < 1) begin : g_bad_order
         $error("cic_comb_chain: ORDER must be at least 1");
      end
      if (SHIFT >= DATA_W) begin : g_bad_shift
         $error("cic_comb_chain: SHIFT must be below DATA_W");
      end
   endgenerate

   logic signed [DATA_W-1:0] tap [ORDER+1];
   logic signed [DATA_W-1:0] dly [ORDER];

   generate
      if (SHIFT == 0) begin : g_no_scale
         assign tap[0] = din;
      end else begin : g_scale
         assign tap[0] = din >>> SHIFT;
      end
   endgenerate

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      assign tap[k+1] = tap[k] - dly[k];

      always_ff @(posedge clk) begin
         if (rst)     dly[k] <= '0;
         else if (en) dly[k] <= tap[k];
      end
   end

   assign dout = tap[ORDER];

   // R3: comb memory changes only when a sample is taken
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
      (!en) |=> $stable(dly[ORDER-1]));

   // R2: first store receives the sign-preserving scaled input
   a_r2_scaled_store: assert property (@(posedge clk) disable iff (rst)
      en |=> (dly[0][DATA_W-1] == $past(din[DATA_W-1])));

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain
   import cic_pkg::*;
#(
   parameter int unsigned DATA_W = CIC_DATA_W,
   parameter int unsigned ORDER  = CIC_ORDER
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     step,
   input  logic signed [DATA_W-1:0] din,
   output logic signed [DATA_W-1:0] dout
);

   logic signed [DATA_W-1:0] acc [ORDER];
   logic signed [DATA_W-1:0] sum [ORDER];

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      if (k == 0) begin : g_head
         assign sum[k] = acc[k] + din;
      end else begin : g_link
         // uses the neighbour's updated value of this same slot
         assign sum[k] = acc[k] + sum[k-1];
      end

      always_ff @(posedge clk) begin
         if (rst)       acc[k] <= '0;
         else if (step) acc[k] <= sum[k];
      end
   end

   assign dout = acc[ORDER-1];

   // R5: a zero slot leaves the first accumulator unchanged
   a_r5_zero_keeps_head: assert property (@(posedge clk) disable iff (rst)
      (step && din == '0) |=> $stable(acc[0]));

   generate
      if (ORDER >= 2) begin : g_chain_chk
         // R5: second stage grows by the fresh first-stage value (R7 wrap)
         a_r5_fresh_chain: assert property (@(posedge clk) disable iff (rst)
            step |=> ((acc[1] - $past(acc[1])) == acc[0]));
      end
   endgenerate

endmodule

// File: rtl/cic_interp.sv
module cic_interp
   import cic_pkg::*;
#(
   parameter int unsigned DATA_W = CIC_DATA_W,
   parameter int unsigned ORDER  = CIC_ORDER,
   parameter int unsigned RATE   = CIC_RATE,
   parameter int unsigned SHIFT  = CIC_SHIFT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("cic_interp: DATA_W must be at least 2");
      end
   endgenerate

   slot_e                    slot;
   logic                     comb_en;
   logic                     step;
   logic signed [DATA_W-1:0] comb_out;
   logic signed [DATA_W-1:0] stuffed;
   logic signed [DATA_W-1:0] integ_out;
   logic                     valid_q;

   cic_rate_ctrl #(.RATE(RATE)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .slot     (slot)
   );

   assign comb_en = (slot == SLOT_SAMPLE);
   assign step    = (slot != SLOT_IDLE);

   cic_comb_chain #(.DATA_W(DATA_W), .ORDER(ORDER), .SHIFT(SHIFT)) u_comb (
      .clk  (clk),
      .rst  (rst),
      .en   (comb_en),
      .din  ($signed(in_data)),
      .dout (comb_out)
   );

   assign stuffed = comb_en ? comb_out : '0;

   cic_integ_chain #(.DATA_W(DATA_W), .ORDER(ORDER)) u_integ (
      .clk  (clk),
      .rst  (rst),
      .step (step),
      .din  (stuffed),
      .dout (integ_out)
   );

   always_ff @(posedge clk) begin
      if (rst) valid_q <= 1'b0;
      else     valid_q <= step;
   end

   assign out_valid = valid_q;
   assign out_data  = integ_out;

   // R4: a taken sample shows up as an output word on the next cycle
   a_r4_accept_emits: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);

   // R4: an owed zero slot always emits a word
   a_r4_zero_emits: assert property (@(posedge clk) disable iff (rst)
      (!in_ready) |=> out_valid);

   // R9: nothing is emitted when idle without a sample
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (in_ready && !in_valid) |=> !out_valid);

   // R6: output word only moves when a slot is processed
   a_r6_out_holds: assert property (@(posedge clk) disable iff (rst)
      (in_ready && !in_valid) |=> $stable(out_data));

endmodule

// File: tb/test_cic_interp.sv
module test_cic_interp;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         in_ready;
   logic         out_valid;
   logic [W-1:0] out_data;

   always #4 clk = ~clk;   // 125 MHz

   cic_interp i_cic_interp (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   typedef struct {
      int    val;
      string tag;
   } exp_t;

   exp_t  expq[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_tag = "R5";

   // reference model state, built from the requirements
   int m_comb[4];
   int m_acc[4];

   function automatic void model_clear();
      for (int k = 0; k < 4; k++) begin
         m_comb[k] = 0;
         m_acc[k]  = 0;
      end
   endfunction

   function automatic void model_slot(int v);
      exp_t e;
      m_acc[0] = m_acc[0] + v;
      for (int k = 1; k < 4; k++) m_acc[k] = m_acc[k] + m_acc[k-1];
      e.val = m_acc[3];
      e.tag = cur_tag;
      expq.push_back(e);
   endfunction

   function automatic void model_take(int x);
      int a;
      int d;
      a = x >>> 3;
      for (int k = 0; k < 4; k++) begin
         d = a - m_comb[k];
         m_comb[k] = a;
         a = d;
      end
      model_slot(a);
      model_slot(0);
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: pops expected words as the design emits them
   always @(negedge clk) begin
      exp_t e;
      if (!rst && out_valid) begin
         if (expq.size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9: actual unexpected word %0d expected none",
                     $signed(out_data));
         end else begin
            e = expq.pop_front();
            chk(e.tag, $signed(out_data), e.val);
         end
      end
   end

   // driver: present one sample, optionally keep in_valid high on junk
   task automatic send(int x, bit poke);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = x;
      model_take(x);
      @(negedge clk);
      chk("R1", int'(in_ready), 0);
      chk("R4", int'(out_valid), 1);
      in_valid = poke;
      in_data  = 32'h7654_3210;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic drain();
      idle(4);
      chk("R4", expq.size(), 0);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      int last;
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R8", int'(out_valid), 0);
      chk("R8", $signed(out_data), 0);
      chk("R8", int'(in_ready), 1);

      // impulse: scaled unit sample, then zeros
      cur_tag = "R5";
      send(8, 1'b0);
      for (int i = 0; i < 8; i++) send(0, 1'b0);
      drain();

      // step held: settles to eight times the scaled value
      cur_tag = "R3";
      for (int i = 0; i < 20; i++) send(80, 1'b0);
      idle(3);
      last = $signed(out_data);
      chk("R6", last, 80);
      drain();

      // sign-preserving scaling
      cur_tag = "R2";
      send(-1, 1'b0);
      send(-9, 1'b0);
      send(7, 1'b0);
      send(-800, 1'b0);
      drain();

      // large swings force accumulator wrap
      cur_tag = "R7";
      for (int i = 0; i < 12; i++)
         send((i % 2 == 0) ? 32'sh7fff_fff8 : 32'sh8000_0000, 1'b0);
      drain();

      // junk held valid during every zero slot
      cur_tag = "R9";
      for (int i = 0; i < 10; i++) send(i * 40 - 100, 1'b1);
      drain();

      // irregular gaps between samples
      cur_tag = "R1";
      for (int i = 0; i < 6; i++) begin
         send(1000 - i * 333, 1'b0);
         idle(i % 3);
      end
      drain();

      // mid-run reset then a fresh impulse
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_clear();
      @(negedge clk);
      chk("R8", int'(out_valid), 0);
      chk("R8", $signed(out_data), 0);
      chk("R8", int'(in_ready), 1);
      cur_tag = "R8";
      send(16, 1'b0);
      for (int i = 0; i < 5; i++) send(0, 1'b0);
      drain();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule